// File: doc/BRIEF.md
# Aliased General Register File

This block holds eight 32-bit general registers behind one write port and two combinational read ports. Every access carries a register index and a two-bit size code. A port can then reach a whole register, its low 16-bit word, or one of two 8-bit lanes. The 8-bit lanes exist only on the first four registers. In byte mode the index picks both the register and the lane. Narrow writes merge into the bits already held. Narrow reads come back zero-extended.

Read port B can also serve as the index operand of an address computation. Register 4 is the stack pointer. Using it as an index operand is illegal, so the block raises a fault flag in the same cycle as that request. Register 5 is the frame base pointer and has no restriction. Reads see a write from the same cycle: the write-first bypass delivers the merged value before the clock edge commits it.

Top module: `gpr_alias_file`

## Requirements
- R1: The file holds eight 32-bit registers with one write port and two independent read ports A and B. Size code 2'b00 (dword) reads or writes all 32 bits of the register named by the 3-bit index.
- R2: Size code 2'b01 (word) reads or writes bits 15:0 of the register named by the index.
- R3: Size codes 2'b10 and 2'b11 (byte) both select a byte lane. Index values 0 to 3 select bits 7:0 of registers 0 to 3. Index values 4 to 7 select bits 15:8 of registers 0 to 3.
- R4: `idx_fault` is 1 in the same cycle when `rd_b_as_index` is 1, the port B size code is dword or word, and `rd_b_idx` is 4. In every other case it is 0, including a byte read with index 4.
- R5: Word and byte reads are zero-extended. Every bit of the read data above the selected field is 0, and the field sits at bit 0.
- R6: A word or byte write changes only the addressed bits. The other bits of that register and all other registers keep their values. Bits of `wr_data` above the write size are ignored.
- R7: Reads are combinational. A read of a register being written in the same cycle returns the merged value that the next edge will store, on both ports.
- R8: Reset is synchronous and active-low. While `rst_n` is low at a rising edge, all registers are cleared to zero. Before that edge, the old contents stay visible.
- R9: While `wr_en` is 0, no register changes, whatever the write index, size and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register or byte-lane index |
| wr_sz | input | 2 | Write size code |
| wr_data | input | 32 | Write data, right-aligned |
| rd_a_idx | input | 3 | Port A index |
| rd_a_sz | input | 2 | Port A size code |
| rd_a_data | output | 32 | Port A zero-extended read data |
| rd_b_idx | input | 3 | Port B index |
| rd_b_sz | input | 2 | Port B size code |
| rd_b_as_index | input | 1 | Port B value is used as an address index operand |
| rd_b_data | output | 32 | Port B zero-extended read data |
| idx_fault | output | 1 | Stack pointer requested as index operand |

## Verification
A write and a read of the same register can fall in one cycle. The bench provokes this by putting a dword write and then a high-byte merge write on the same register. In each case it reads the register back before the edge on both ports. It judges the result against the merged value it predicts from the previous contents. A fault request also shares its cycle with an ordinary port B read. That case is judged on the flag and the returned data together, and byte index 4 confirms that the high-byte alias of register 0 does not trip the flag.

// File: rtl/gpr_pkg.sv
// Package: shared size-code encoding for the aliased register file.
// Assumes size codes are two bits wide. Bit 1 set means byte access.
package gpr_pkg;
    typedef enum logic [1:0] {
        SZ_DWORD  = 2'b00,
        SZ_WORD   = 2'b01,
        SZ_BYTE   = 2'b10,
        SZ_BYTE_X = 2'b11
    } gpr_size_e;

    // True when a size code selects one byte lane.
    function automatic logic size_is_byte(input logic [1:0] sz);
        return sz[1];
    endfunction
endpackage

// File: rtl/gpr_port_decode.sv
// Module: gpr_port_decode
// Turns an index and a size code into a physical register number, a lane
// mask and a high-lane flag. It is used by the write port and by both read
// ports. Assumes IDX_W equals log2(NUM_BYTE_REGS) + 1, so that the top index
// bit picks the high byte lane in byte mode.
module gpr_port_decode
    import gpr_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int WORD_W        = 16,
    parameter int BYTE_W        = 8,
    parameter int IDX_W         = 3,
    parameter int NUM_BYTE_REGS = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        sz,
    output logic [IDX_W-1:0]  phys,
    output logic [DATA_W-1:0] lane_mask,
    output logic              hi_lane
);
    localparam int BSEL_W = $clog2(NUM_BYTE_REGS);
    localparam logic [DATA_W-1:0] MASK_DWORD = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] MASK_WORD  = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
    localparam logic [DATA_W-1:0] MASK_BLO   = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [DATA_W-1:0] MASK_BHI   = MASK_BLO << BYTE_W;

    // Decode the index and size into a register number and the bits it covers.
    always_comb begin
        phys      = idx;
        hi_lane   = 1'b0;
        lane_mask = MASK_DWORD;
        if (size_is_byte(sz)) begin
            phys      = IDX_W'(idx[BSEL_W-1:0]);
            hi_lane   = idx[BSEL_W];
            lane_mask = idx[BSEL_W] ? MASK_BHI : MASK_BLO;
        end else if (gpr_size_e'(sz) == SZ_WORD) begin
            lane_mask = MASK_WORD;
        end
    end
endmodule

// File: rtl/gpr_storage.sv
// Module: gpr_storage
// Holds the registers and merges masked writes into them. Its output is the
// next-state view of every register, which serves as the write-first bypass
// for the read ports. Assumes wr_aligned already sits in the target lane.
module gpr_storage #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_phys,
    input  logic [DATA_W-1:0]                wr_mask,
    input  logic [DATA_W-1:0]                wr_aligned,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  view
);
    logic [NUM_REGS-1:0][DATA_W-1:0] q;
    logic [NUM_REGS-1:0][DATA_W-1:0] nxt;
    logic [NUM_REGS-1:0]             hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Form the merged next value of this register.
        always_comb begin
            hit[g] = wr_en && (wr_phys == IDX_W'(g));
            nxt[g] = hit[g] ? ((q[g] & ~wr_mask) | (wr_aligned & wr_mask)) : q[g];
        end

        // Commit the next value, or clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q[g] <= '0;
            else        q[g] <= nxt[g];
        end

        // R9 / R6: a register that was not addressed keeps its value.
        p_hold_unaddressed_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[g] |=> $stable(q[g]));

        // R6: the bits outside the lane survive a narrow write.
        p_merge_keeps_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> ((q[g] & ~$past(wr_mask)) == ($past(q[g]) & ~$past(wr_mask))));

        // R8: the first cycle after reset sees a cleared register.
        p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (q[g] == '0));
    end

    assign view = nxt;
endmodule

// File: rtl/gpr_read_port.sv
// Module: gpr_read_port
// Selects one register from the bypass view, keeps the lane and shifts the
// high byte down to bit 0. The result is zero-extended. It is purely
// combinational. The clock and reset are used only by its assertions.
module gpr_read_port #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int WORD_W   = 16,
    parameter int BYTE_W   = 8,
    parameter int IDX_W    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  view,
    input  logic [IDX_W-1:0]                 phys,
    input  logic [DATA_W-1:0]                lane_mask,
    input  logic                             hi_lane,
    output logic [DATA_W-1:0]                data
);
    logic [DATA_W-1:0] masked;

    // Pick the register, keep the lane and right-align a high byte.
    always_comb begin
        masked = view[phys] & lane_mask;
        data   = hi_lane ? (masked >> BYTE_W) : masked;
    end

    // R5: a narrow read leaves the upper half zero.
    p_narrow_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_mask[DATA_W-1] |-> ((data >> WORD_W) == '0));

    // R5 / R3: a high-byte read returns only eight bits.
    p_hibyte_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hi_lane |-> ((data >> BYTE_W) == '0));
endmodule

// File: rtl/gpr_alias_file.sv
// Module: gpr_alias_file (top)
// Register file with dword, word and byte aliasing. It has one write port
// and two read ports, and read port B can serve as an address index. The
// block flags the stack-pointer register when it is used as an index.
// Assumes the caller keeps rst_n low for at least one rising edge.
module gpr_alias_file #(
    parameter int NUM_REGS      = 8,
    parameter int DATA_W        = 32,
    parameter int WORD_W        = 16,
    parameter int BYTE_W        = 8,
    parameter int NUM_BYTE_REGS = 4,
    parameter int SP_IDX        = 4,
    parameter int IDX_W         = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_sz,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [1:0]        rd_a_sz,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic [1:0]        rd_b_sz,
    input  logic              rd_b_as_index,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              idx_fault
);
    import gpr_pkg::*;

    localparam int NUM_PORTS = 3;   // port 0 write, 1 read A, 2 read B

    logic [NUM_PORTS-1:0][IDX_W-1:0]  p_idx;
    logic [NUM_PORTS-1:0][1:0]        p_sz;
    logic [NUM_PORTS-1:0][IDX_W-1:0]  p_phys;
    logic [NUM_PORTS-1:0][DATA_W-1:0] p_mask;
    logic [NUM_PORTS-1:0]             p_hi;
    logic [NUM_REGS-1:0][DATA_W-1:0]  view;
    logic [DATA_W-1:0]                wr_aligned;

    assign p_idx = {rd_b_idx, rd_a_idx, wr_idx};
    assign p_sz  = {rd_b_sz,  rd_a_sz,  wr_sz};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        gpr_port_decode #(
            .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W),
            .IDX_W(IDX_W), .NUM_BYTE_REGS(NUM_BYTE_REGS)
        ) u_dec (
            .idx(p_idx[p]), .sz(p_sz[p]), .phys(p_phys[p]),
            .lane_mask(p_mask[p]), .hi_lane(p_hi[p])
        );
    end

    // Move right-aligned write data into a high byte lane when one is targeted.
    always_comb wr_aligned = p_hi[0] ? (wr_data << BYTE_W) : wr_data;

    gpr_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_phys(p_phys[0]),
        .wr_mask(p_mask[0]), .wr_aligned(wr_aligned), .view(view)
    );

    gpr_read_port #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .WORD_W(WORD_W),
        .BYTE_W(BYTE_W), .IDX_W(IDX_W)
    ) u_rd_a (
        .clk(clk), .rst_n(rst_n), .view(view), .phys(p_phys[1]),
        .lane_mask(p_mask[1]), .hi_lane(p_hi[1]), .data(rd_a_data)
    );

    gpr_read_port #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .WORD_W(WORD_W),
        .BYTE_W(BYTE_W), .IDX_W(IDX_W)
    ) u_rd_b (
        .clk(clk), .rst_n(rst_n), .view(view), .phys(p_phys[2]),
        .lane_mask(p_mask[2]), .hi_lane(p_hi[2]), .data(rd_b_data)
    );

    // Flag the stack pointer when a non-byte port B read is an index operand.
    always_comb idx_fault = rd_b_as_index && !size_is_byte(rd_b_sz)
                            && (rd_b_idx == IDX_W'(SP_IDX));

    // R4: no fault without an index-operand request.
    p_fault_needs_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_b_as_index |-> !idx_fault);

    // R4: a fault always names the stack-pointer index.
    p_fault_only_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_fault |-> (rd_b_idx == IDX_W'(SP_IDX)));

    // R7: a same-cycle dword write to the read register is visible on port A.
    p_write_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sz == 2'b00 && rd_a_sz == 2'b00 && rd_a_idx == wr_idx)
        |-> (rd_a_data == wr_data));

    // R3: a byte access never lands above the byte-capable registers.
    p_byte_phys_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        p_hi[1] |-> (p_phys[1] < IDX_W'(NUM_BYTE_REGS)));
endmodule

// File: tb/gpr_alias_file_bench.sv
// Bench for gpr_alias_file. A vector table runs write-then-read steps,
// followed by directed tests for reset, bypass, the two ports and the fault.
module gpr_alias_file_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    typedef struct packed {
        logic        we;
        logic [2:0]  widx;
        logic [1:0]  wsz;
        logic [31:0] wdat;
        logic [2:0]  ridx;
        logic [1:0]  rsz;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Each step: optional write, commit at the edge, then a port A read check.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd0, 2'b00, 32'h11223344, 3'd0, 2'b00, 32'h11223344, 4'd1}, // R1
        '{1'b1, 3'd0, 2'b10, 32'h000000AA, 3'd0, 2'b00, 32'h112233AA, 4'd6}, // R6 low byte r0
        '{1'b1, 3'd4, 2'b10, 32'h00000055, 3'd0, 2'b00, 32'h112255AA, 4'd3}, // R3 high byte r0
        '{1'b1, 3'd0, 2'b01, 32'hFFFFBEEF, 3'd0, 2'b00, 32'h1122BEEF, 4'd2}, // R2 word, upper ignored
        '{1'b0, 3'd0, 2'b00, 32'h00000000, 3'd4, 2'b10, 32'h000000BE, 4'd3}, // R3 high byte read
        '{1'b0, 3'd0, 2'b00, 32'h00000000, 3'd0, 2'b10, 32'h000000EF, 4'd5}, // R5 low byte zero-ext
        '{1'b1, 3'd3, 2'b00, 32'hCAFEF00D, 3'd7, 2'b10, 32'h000000F0, 4'd3}, // R3 high byte r3
        '{1'b0, 3'd0, 2'b00, 32'h00000000, 3'd3, 2'b01, 32'h0000F00D, 4'd5}, // R5 word zero-ext
        '{1'b1, 3'd7, 2'b00, 32'h80000001, 3'd7, 2'b01, 32'h00000001, 4'd2}, // R2 word r7
        '{1'b1, 3'd7, 2'b10, 32'h00000012, 3'd3, 2'b00, 32'hCAFE120D, 4'd6}, // R6 merge high r3
        '{1'b1, 3'd4, 2'b01, 32'h00001234, 3'd4, 2'b00, 32'h00001234, 4'd2}, // R2 word on r4
        '{1'b1, 3'd5, 2'b11, 32'h0000007F, 3'd1, 2'b00, 32'h00007F00, 4'd3}, // R3 alt byte code
        '{1'b0, 3'd0, 2'b00, 32'h00000000, 3'd5, 2'b00, 32'h00000000, 4'd6}, // R6 r5 untouched
        '{1'b0, 3'd6, 2'b00, 32'hFFFFFFFF, 3'd6, 2'b00, 32'h00000000, 4'd9}  // R9 write disabled
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_sz;
    logic [31:0] wr_data;
    logic [2:0]  rd_a_idx;
    logic [1:0]  rd_a_sz;
    logic [31:0] rd_a_data;
    logic [2:0]  rd_b_idx;
    logic [1:0]  rd_b_sz;
    logic        rd_b_as_index;
    logic [31:0] rd_b_data;
    logic        idx_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpr_alias_file u_gpr_alias_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sz(wr_sz),
        .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_sz(rd_a_sz),
        .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_sz(rd_b_sz),
        .rd_b_as_index(rd_b_as_index), .rd_b_data(rd_b_data), .idx_fault(idx_fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_a(input logic [2:0] i, input logic [1:0] s);
        rd_a_idx = i; rd_a_sz = s; #1;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_sz = '0; wr_data = '0;
        rd_a_idx = '0; rd_a_sz = '0; rd_b_idx = '0; rd_b_sz = '0; rd_b_as_index = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R8: every register reads zero after reset.
        for (int r = 0; r < 8; r++) begin
            rd_a(3'(r), 2'b00);
            check($sformatf("R8 reset r%0d", r), rd_a_data, 32'h0);
        end

        // Vector table walk.
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            wr_en = VECS[k].we; wr_idx = VECS[k].widx; wr_sz = VECS[k].wsz;
            wr_data = VECS[k].wdat;
            @(posedge clk); #1;
            wr_en = 1'b0;
            rd_a(VECS[k].ridx, VECS[k].rsz);
            check($sformatf("R%0d vec%0d", VECS[k].req, k), rd_a_data, VECS[k].exp);
        end

        // R7: dword write to r2 visible before the edge.
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd2; wr_sz = 2'b00; wr_data = 32'hDEADBEEF;
        rd_a(3'd2, 2'b00);
        check("R7 dword bypass", rd_a_data, 32'hDEADBEEF);
        // R7: high-byte merge on r2 visible on both ports in the same cycle.
        @(negedge clk);
        wr_idx = 3'd6; wr_sz = 2'b10; wr_data = 32'h00000077;
        rd_b_idx = 3'd2; rd_b_sz = 2'b01;
        rd_a(3'd2, 2'b00);
        check("R7 merge bypass A", rd_a_data, 32'hDEAD77EF);
        check("R7 merge bypass B", rd_b_data, 32'h000077EF);
        @(posedge clk); #1; wr_en = 1'b0;
        rd_a(3'd2, 2'b00);
        check("R7 merge committed", rd_a_data, 32'hDEAD77EF);

        // R1: both ports read different registers at once.
        rd_b_idx = 3'd3; rd_b_sz = 2'b00;
        rd_a(3'd7, 2'b00);
        check("R1 port A r7", rd_a_data, 32'h80000001);
        check("R1 port B r3", rd_b_data, 32'hCAFE120D);
        // R3: byte code 2'b11 aliases 2'b10 on a read.
        rd_a(3'd6, 2'b11);
        check("R3 alt code read", rd_a_data, 32'h00000077);

        // R4: fault cases.
        rd_b_as_index = 1'b1; rd_b_idx = 3'd4; rd_b_sz = 2'b00; #1;
        check("R4 sp dword index", {31'b0, idx_fault}, 32'h1);
        check("R4 sp dword data", rd_b_data, 32'h00001234);
        rd_b_sz = 2'b01; #1;
        check("R4 sp word index", {31'b0, idx_fault}, 32'h1);
        rd_b_sz = 2'b10; #1;
        check("R4 byte idx4 no fault", {31'b0, idx_fault}, 32'h0);
        check("R4 byte idx4 data", rd_b_data, 32'h000000BE);
        rd_b_idx = 3'd5; rd_b_sz = 2'b00; #1;
        check("R4 bp index no fault", {31'b0, idx_fault}, 32'h0);
        rd_b_as_index = 1'b0; rd_b_idx = 3'd4; #1;
        check("R4 sp as base no fault", {31'b0, idx_fault}, 32'h0);

        // R8: synchronous reset keeps contents until the edge.
        @(negedge clk); rst_n = 1'b0;
        rd_a(3'd0, 2'b00);
        check("R8 before edge", rd_a_data, 32'h1122BEEF);
        @(posedge clk); #1;
        rd_a(3'd0, 2'b00);
        check("R8 cleared r0", rd_a_data, 32'h0);
        rd_a(3'd3, 2'b00);
        check("R8 cleared r3", rd_a_data, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule